// File: doc/BRIEF.md
# Banked Interrupt Aggregator

This block gathers twenty-four interrupt request lines into one interrupt line for a host processor. The requests are grouped into three byte-wide banks. Each bank has a status byte that records requests and a mask byte that enables them. A byte-wide register port with a three-bit address gives access to all six bytes. The host sees a single combined line and is expected to react to its rising edge. It then reads the status bytes to find which sources fired.

Most request lines are edge-captured. A rising edge on an enabled line sets a sticky status bit. Reading the status byte that holds the bit returns it and clears it. No separate acknowledge exists. One request line, chosen by a parameter, is level-sensitive instead. Its status bit simply follows the synchronized request and is never cleared by a read. An edge that arrives while its line is disabled is dropped. Enabling the line later does not bring that edge back.

Top module: `irq_agg`

## Requirements
- R1: After reset, all three mask bytes read 0x00, every edge status bit is 0 and `irqOut` is 0.
- R2: A write to address 1, 3 or 5 loads the low, middle or upper mask byte. A mask bit of 1 enables its input and a 0 disables it. Reading the same address returns the byte that was written.
- R3: Request input i maps to bit i mod 8 of bank i div 8. Addresses 0, 2 and 4 read the status bytes of banks 0, 1 and 2. A rising edge on an enabled edge input sets its status bit. The request passes a two-flop synchronizer and a delayed copy, so the bit is set on the third clock after the request rises.
- R4: Read data appears on `rdData` one clock after the read strobe and shows the status byte as it was before the read. On the strobe's own clock, the read clears the edge bits of that byte only.
- R5: An edge that arrives while its mask bit is 0 is not recorded. It does not become pending when the bit is set later.
- R6: The level input, index `LEVEL_IDX` (default 12, which is bank 1 bit 4), has a status bit equal to its synchronized request. This holds whatever its mask bit is. A status read does not clear it.
- R7: `irqOut` is a register that holds the OR over all 24 bits of status AND mask, taken on the previous clock. Clearing a mask bit removes that source from the output, but its status bit is kept.
- R8: If a new edge is detected in the same cycle as a read-clear of its byte, the bit remains set after the read.
- R9: Writes to the status addresses 0, 2 and 4 change no register. Reads of addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 24 | Asynchronous interrupt request lines |
| rdEn | input | 1 | Read strobe for the byte at `addr` |
| wrEn | input | 1 | Write strobe for the byte at `addr` |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data, valid one clock after `rdEn` |
| irqOut | output | 1 | Combined interrupt line to the host |

## Verification
Two functions can act on one status bit in the same clock: the read-clear of a status byte and the capture of a new edge into that byte. The bench raises a request exactly two clocks before it strobes a read of the same byte. The edge is detected in the strobe cycle. The bench then checks three results in turn: the returned byte still shows only the older pending bit, the following read shows only the new bit, and a third read returns zero. A second overlap is also tested: a mask write that disables a pending source. The bench expects `irqOut` to drop one clock after the write while the status bit stays readable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int BANK_W     = 8;
  localparam int NUM_BANKS  = 3;
  localparam int NUM_REQ    = BANK_W * NUM_BANKS;
  localparam int ADDR_W     = 3;
  localparam int BANK_IDX_W = ADDR_W - 1;

  // Strobes from address decode to the datapath
  typedef struct packed {
    logic [NUM_BANKS-1:0]  statClr;
    logic [NUM_BANKS-1:0]  maskWr;
    logic                  rdStb;
    logic                  rdHit;
    logic                  rdIsMask;
    logic [BANK_IDX_W-1:0] rdBank;
  } ctrlStb_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStb_t          stb
);
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  isMask;
  logic                  inRange;

  assign bankIdx = addr[ADDR_W-1:1];
  assign isMask  = addr[0];
  assign inRange = (bankIdx < BANK_IDX_W'(NUM_BANKS));

  always_comb begin
    stb          = '0;
    stb.rdStb    = rdEn;
    stb.rdHit    = rdEn & inRange;
    stb.rdIsMask = isMask;
    stb.rdBank   = bankIdx;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankIdx == BANK_IDX_W'(b)) begin
        stb.statClr[b] = rdEn & ~isMask;
        stb.maskWr[b]  = wrEn & isMask;
      end
    end
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_IDX = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqIn,
  input  logic [BANK_W-1:0]  wrData,
  input  ctrlStb_t           stb,
  output logic [BANK_W-1:0]  rdData,
  output logic               irqOut,
  output logic [NUM_REQ-1:0] statusVec,
  output logic [NUM_REQ-1:0] maskVec,
  output logic [NUM_REQ-1:0] setVec,
  output logic [NUM_REQ-1:0] pendVec
);
  localparam logic [NUM_REQ-1:0] LEVEL_SEL = NUM_REQ'(1) << LEVEL_IDX;
  localparam logic [NUM_REQ-1:0] EDGE_SEL  = ~LEVEL_SEL;

  logic [NUM_REQ-1:0] syncA, syncB, syncDly;
  logic [NUM_REQ-1:0] edgeDet;
  logic [NUM_REQ-1:0] edgeStat;
  logic [NUM_REQ-1:0] clrVec;
  logic [BANK_W-1:0]  statBank [NUM_BANKS];
  logic [BANK_W-1:0]  maskBank [NUM_BANKS];
  logic [BANK_W-1:0]  rdNext;

  // Synchronizer and delayed copy
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA   <= '0;
      syncB   <= '0;
      syncDly <= '0;
    end else begin
      syncA   <= reqIn;
      syncB   <= syncA;
      syncDly <= syncB;
    end
  end

  assign edgeDet = syncB & ~syncDly;
  assign setVec  = edgeDet & maskVec & EDGE_SEL;

  // Per-bank views and clear vector
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign clrVec[b*BANK_W +: BANK_W] = {BANK_W{stb.statClr[b]}};
    assign statBank[b] = statusVec[b*BANK_W +: BANK_W];
    assign maskBank[b] = maskVec[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      maskVec <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.maskWr[b]) maskVec[b*BANK_W +: BANK_W] <= wrData;
      end
    end
  end

  // Sticky edge capture; a fresh edge outranks the read-clear
  always_ff @(posedge clk) begin
    if (rst) edgeStat <= '0;
    else     edgeStat <= ((edgeStat & ~clrVec) | setVec) & EDGE_SEL;
  end

  assign statusVec = edgeStat | (syncB & LEVEL_SEL);
  assign pendVec   = statusVec & maskVec;

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (stb.rdHit && stb.rdBank == BANK_IDX_W'(b))
        rdNext = stb.rdIsMask ? maskBank[b] : statBank[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
      irqOut <= 1'b0;
    end else begin
      if (stb.rdStb) rdData <= rdNext;
      irqOut <= |pendVec;
    end
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_IDX = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] reqIn,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BANK_W-1:0]  wrData,
  output logic [BANK_W-1:0]  rdData,
  output logic               irqOut
);
  ctrlStb_t           stb;
  logic [NUM_REQ-1:0] statusVec, maskVec, setVec, pendVec;

  irq_agg_ctrl u_ctrl (
    .rdEn (rdEn),
    .wrEn (wrEn),
    .addr (addr),
    .stb  (stb)
  );

  irq_agg_dp #(.LEVEL_IDX(LEVEL_IDX)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .reqIn     (reqIn),
    .wrData    (wrData),
    .stb       (stb),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .setVec    (setVec),
    .pendVec   (pendVec)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int LEVEL_IDX = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               rdEn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [BANK_W-1:0]  wrData,
  input logic               irqOut,
  input logic [NUM_REQ-1:0] statusVec,
  input logic [NUM_REQ-1:0] maskVec,
  input logic [NUM_REQ-1:0] setVec,
  input logic [NUM_REQ-1:0] pendVec
);
  localparam logic [NUM_REQ-1:0] EDGE_SEL = ~(NUM_REQ'(1) << LEVEL_IDX);

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && addr == ADDR_W'(1)) |=> (maskVec[BANK_W-1:0] == $past(wrData)));

  // R4
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && addr == ADDR_W'(0)) |=>
      ((statusVec[BANK_W-1:0] & EDGE_SEL[BANK_W-1:0]) == $past(setVec[BANK_W-1:0])));

  // R5
  masked_lost_chk: assert property (@(posedge clk) disable iff (rst)
    ((statusVec & ~$past(statusVec) & ~$past(maskVec) & EDGE_SEL) == '0));

  // R7
  irq_or_chk: assert property (@(posedge clk) disable iff (rst)
    irqOut == $past(|pendVec));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ((~statusVec & $past(setVec)) == '0));

  // R9
  stat_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !addr[0]) |=> $stable(maskVec));
endmodule

bind irq_agg irq_agg_chk #(.LEVEL_IDX(LEVEL_IDX)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .addr      (addr),
  .wrData    (wrData),
  .irqOut    (irqOut),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .setVec    (setVec),
  .pendVec   (pendVec)
);

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] reqIn = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        irqOut;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];
  logic       rdSeen = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  irq_agg u_irq_agg (
    .clk(clk), .rst(rst), .reqIn(reqIn), .rdEn(rdEn), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: compare read data one clock after each strobe
  always @(posedge clk) rdSeen <= rdEn;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        check(1'b0, "read without expectation", int'(rdData), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, int'(rdData), int'(e));
      end
    end
  end

  // Driver tasks, called at a falling edge
  task automatic readReg(input logic [2:0] a, input logic [7:0] e, input string t);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseReq(input int i);
    reqIn[i] = 1'b1;
    repeat (2) @(negedge clk);
    reqIn[i] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkIrq(input logic e, input string t);
    check(irqOut == e, t, int'(irqOut), int'(e));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    checkIrq(1'b0, "R1 irqOut after reset");
    readReg(3'd1, 8'h00, "R1 low mask");
    readReg(3'd3, 8'h00, "R1 mid mask");
    readReg(3'd5, 8'h00, "R1 high mask");
    readReg(3'd0, 8'h00, "R1 low status");
    readReg(3'd4, 8'h00, "R1 high status");

    // R2 mask load and read-back
    writeReg(3'd1, 8'hA5); readReg(3'd1, 8'hA5, "R2 low mask");
    writeReg(3'd3, 8'h3C); readReg(3'd3, 8'h3C, "R2 mid mask");
    writeReg(3'd5, 8'hFF); readReg(3'd5, 8'hFF, "R2 high mask");
    writeReg(3'd1, 8'hFF); writeReg(3'd3, 8'hFF); writeReg(3'd5, 8'h00);

    // R9 status writes ignored, unused addresses read zero
    writeReg(3'd0, 8'hFF); writeReg(3'd2, 8'h00);
    readReg(3'd0, 8'h00, "R9 status write ignored");
    readReg(3'd3, 8'hFF, "R9 mask untouched");
    readReg(3'd6, 8'h00, "R9 address 6");
    readReg(3'd7, 8'h00, "R9 address 7");

    // R3 / R4 / R7 capture, read-clear, combined output
    pulseReq(3);
    checkIrq(1'b1, "R7 irq after edge");
    readReg(3'd0, 8'h08, "R3 bit 3 captured");
    readReg(3'd0, 8'h00, "R4 cleared by read");
    @(negedge clk);
    checkIrq(1'b0, "R7 irq drops after clear");

    // R4 clear is per byte
    pulseReq(1); pulseReq(9);
    readReg(3'd0, 8'h02, "R3 bank0 bit1");
    readReg(3'd2, 8'h02, "R4 bank1 survives bank0 read");
    readReg(3'd2, 8'h00, "R4 bank1 cleared");

    // R5 masked edges lost
    pulseReq(17);
    checkIrq(1'b0, "R5 no irq when masked");
    writeReg(3'd5, 8'hFF);
    repeat (2) @(negedge clk);
    checkIrq(1'b0, "R5 unmask brings nothing");
    readReg(3'd4, 8'h00, "R5 masked edge not stored");
    pulseReq(17);
    readReg(3'd4, 8'h02, "R3 bank2 bit1");

    // R7 masking a pending bit
    pulseReq(5);
    checkIrq(1'b1, "R7 irq for bit 5");
    writeReg(3'd1, 8'h00);
    @(negedge clk);
    checkIrq(1'b0, "R7 mask removes source");
    readReg(3'd0, 8'h20, "R7 status kept while masked");
    writeReg(3'd1, 8'hFF);

    // R6 level input
    reqIn[12] = 1'b1;
    repeat (3) @(negedge clk);
    checkIrq(1'b1, "R6 level raises irq");
    readReg(3'd2, 8'h10, "R6 level status");
    readReg(3'd2, 8'h10, "R6 not cleared by read");
    writeReg(3'd3, 8'hEF);
    @(negedge clk);
    checkIrq(1'b0, "R6 level masked");
    readReg(3'd2, 8'h10, "R6 status independent of mask");
    reqIn[12] = 1'b0;
    repeat (3) @(negedge clk);
    readReg(3'd2, 8'h00, "R6 follows level low");
    writeReg(3'd3, 8'hFF);

    // R8 edge in the same cycle as read-clear
    pulseReq(1);
    reqIn[0] = 1'b1;
    repeat (2) @(negedge clk);
    readReg(3'd0, 8'h02, "R8 read returns old byte");
    readReg(3'd0, 8'h01, "R8 new edge kept");
    readReg(3'd0, 8'h00, "R8 cleared afterwards");
    reqIn[0] = 1'b0;

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "reads outstanding", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule